// File: doc/BRIEF.md
# Self-Correcting Word Memory with Background Scrub

This block is a small on-chip memory that guards every 128-bit word with 8 check bits it generates itself. The host writes only data. The block works out the check bits and stores them with the word as a 136-bit codeword. On every read it recomputes the syndrome from the stored codeword. It repairs any single flipped bit before the data reaches the read port, and it raises a one-cycle flag when it has done so.

A scrub walker runs whenever scrubbing is enabled and the host leaves the port idle. Each idle cycle it examines one stored word. When it finds a flipped bit it writes the repaired codeword back in place and adds one to an error counter that the host can read and clear. A test-only port inverts one chosen stored bit, so correction and repair can be exercised from outside the block.

Top module: `sec_scrub_mem`

## Requirements
- R1: A synchronous active-low reset clears all 16 stored words to the all-zero codeword, which is the valid codeword for zero data. It also clears the error counter and the scrub pointer to 0 and drives `rd_valid` and `rd_corrected` low.
- R2: When `req_valid`=1 and `req_we`=1 on a clock edge, the word at `req_addr` is replaced. When `req_valid`=1 and `req_we`=0, `rd_valid` is high for exactly the following cycle, and `rd_data` then holds the data stored at `req_addr`.
- R3: Check bits come only from inside the block. The stored codeword uses positions 1 to 136, and position p sits in stored bit p-1. Check bits occupy positions 1, 2, 4, 8, 16, 32, 64 and 128. Data bits fill the remaining positions in ascending order, and each check bit gives even parity over all positions whose index shares its set bit.
- R4: If exactly one stored bit of a word is inverted, a host read returns the original data with `rd_corrected`=1 in the `rd_valid` cycle. A read of an intact word gives `rd_corrected`=0.
- R5: A host read never writes back. Reading a word with one flipped bit twice, with no scrub in between, reports `rd_corrected`=1 both times.
- R6: When `scrub_en`=1 and `req_valid`=0, the walker checks the word at its pointer on that edge and then moves the pointer one step, going from word 15 back to word 0. If the word held a single flipped bit, the repaired codeword is written back and the counter goes up by one.
- R7: A host request in a cycle takes priority over scrubbing. The pointer holds and no write-back happens, and the step is taken on the next idle cycle.
- R8: `err_count` is 16 bits wide and stays at 0xFFFF once it gets there.
- R9: `err_clr`=1 sets the counter to 0 on that edge. This wins over a repair counted on the same edge.
- R10: `inj_valid`=1 inverts stored bit `inj_bit` (0 to 135) of word `inj_addr`. This is applied after any write to that word on the same edge. Values of `inj_bit` from 136 to 255 change nothing.
- R11: While `scrub_en`=0, the pointer and the counter hold (apart from `err_clr`), and stored words are not repaired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 128 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 128 | Corrected read data |
| rd_corrected | output | 1 | Read needed a single-bit repair |
| scrub_en | input | 1 | Enable background scrubbing |
| err_clr | input | 1 | Clear the error counter |
| err_count | output | 16 | Saturating count of scrub repairs |
| inj_valid | input | 1 | Test: invert one stored bit |
| inj_addr | input | 4 | Test: word to corrupt |
| inj_bit | input | 8 | Test: stored bit index to invert |

## Verification
The bench injects flips at the edges of the codeword layout: the lowest and highest data positions, the check-bit positions themselves, and out-of-range indices. A wrong position map or syndrome would return altered data or miss the flag. It also reads damaged words repeatedly with scrubbing off, which exposes a design that wrongly repairs on a host read. Host requests are interleaved with scrub steps and flips are placed at word 15 and word 0, so a walker that skips a step under host traffic, or does not wrap, counts at the wrong time. Finally it drives the counter past 65535 repairs and pulses a clear during a repair, which catches a counter that wraps to zero or lets the increment win.

// File: rtl/sec_scrub_pkg.sv
// Package: shared helpers for the single-error-correcting word memory.
// Assumes a Hamming layout with check bits at power-of-two positions.
package sec_scrub_pkg;

    // Number of check bits needed to correct one error in dw data bits.
    function automatic int chk_bits(input int dw);
        int r;
        r = 1;
        while ((1 << r) < (dw + r + 1)) begin
            r++;
        end
        return r;
    endfunction

    // True when a codeword position (1-based) holds a check bit.
    function automatic bit is_chk_pos(input int p);
        return (p & (p - 1)) == 0;
    endfunction

endpackage

// File: rtl/sec_encoder.sv
// Module: sec_encoder
// Builds a Hamming codeword from a data word. Data bits fill the non-power-of-two
// positions in ascending order; the check bit at position 2^k is the even parity of
// every position that has bit k set. Purely combinational.
module sec_encoder
    import sec_scrub_pkg::*;
#(
    parameter int DATA_W = 128,
    localparam int CHK_W = chk_bits(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);

    logic [CW_W-1:0] placed;

    // Place data bits at the non-check positions.
    always_comb begin
        int di;
        placed = '0;
        di = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_chk_pos(p)) begin
                placed[p-1] = data_i[di];
                di++;
            end
        end
    end

    // Fill each check position with the parity of its coverage group.
    always_comb begin
        logic par;
        cw_o = placed;
        for (int k = 0; k < CHK_W; k++) begin
            par = 1'b0;
            for (int p = 1; p <= CW_W; p++) begin
                if ((p & (1 << k)) != 0) begin
                    par = par ^ placed[p-1];
                end
            end
            cw_o[(1 << k) - 1] = par;
        end
    end

endmodule

// File: rtl/sec_decoder.sv
// Module: sec_decoder
// Recomputes the syndrome of a stored codeword, inverts the position it names
// (if within the codeword) and extracts the data bits. Assumes at most one flip;
// a double flip yields wrong data without any indication. Purely combinational.
module sec_decoder
    import sec_scrub_pkg::*;
#(
    parameter int DATA_W = 128,
    localparam int CHK_W = chk_bits(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W
) (
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o
);

    logic [CHK_W-1:0] syn;
    logic [CW_W-1:0]  fixed;

    // Syndrome: XOR of the indices of every set position.
    always_comb begin
        syn = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if (cw_i[p-1]) begin
                syn = syn ^ CHK_W'(p);
            end
        end
    end

    // Invert the position the syndrome names.
    always_comb begin
        fixed = cw_i;
        for (int p = 1; p <= CW_W; p++) begin
            if (syn == CHK_W'(p)) begin
                fixed[p-1] = ~cw_i[p-1];
            end
        end
    end

    // Pull the data bits out of the repaired codeword.
    always_comb begin
        int di;
        data_o = '0;
        di = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_chk_pos(p)) begin
                data_o[di] = fixed[p-1];
                di++;
            end
        end
    end

    // Flag any nonzero syndrome.
    assign err_o = (syn != '0);

endmodule

// File: rtl/sec_scrub_ctrl.sv
// Module: sec_scrub_ctrl
// Scrub walker: owns the scrub pointer and the saturating repair counter.
// One step per cycle in which scrubbing is enabled and the host is idle.
// Assumes the caller performs the write-back when wb_en_o is high.
module sec_scrub_ctrl #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scrub_en_i,
    input  logic             host_busy_i,
    input  logic             word_err_i,
    input  logic             err_clr_i,
    output logic [AW-1:0]    ptr_o,
    output logic             wb_en_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic step;

    assign step    = scrub_en_i && !host_busy_i;
    assign wb_en_o = step && word_err_i;

    // Advance the pointer once per scrub step, wrapping at the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o <= '0;
        end else if (step) begin
            ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
        end
    end

    // Count repairs, saturate at all ones, clear on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (err_clr_i) begin
            count_o <= '0;
        end else if (wb_en_o && (count_o != '1)) begin
            count_o <= count_o + 1'b1;
        end
    end

    p_ptr_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_en_i && !host_busy_i) |=>
            (ptr_o == (($past(ptr_o) == LAST) ? '0 : $past(ptr_o) + 1'b1)));

    p_host_holds_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy_i |=> $stable(ptr_o));

    p_count_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_o == '1) && !err_clr_i) |=> (count_o == '1));

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_i |=> (count_o == '0));

    p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!scrub_en_i && !err_clr_i) |=> ($stable(ptr_o) && $stable(count_o)));

endmodule

// File: rtl/sec_scrub_mem.sv
// Module: sec_scrub_mem (top)
// Register-based memory of DEPTH codewords. Host writes are encoded in the block;
// host reads are decoded and corrected, registered one cycle later. An idle-time
// scrub walker repairs stored words and counts repairs. A test port inverts one
// stored bit. Assumes at most one flipped bit per word between repairs.
module sec_scrub_mem
    import sec_scrub_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 128,
    parameter int CNT_W  = 16,
    localparam int CHK_W = chk_bits(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int BW    = $clog2(CW_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_corrected,
    input  logic              scrub_en,
    input  logic              err_clr,
    output logic [CNT_W-1:0]  err_count,
    input  logic              inj_valid,
    input  logic [AW-1:0]     inj_addr,
    input  logic [BW-1:0]     inj_bit
);

    localparam int PORT_HOST  = 0;
    localparam int PORT_SCRUB = 1;
    localparam int NPORT      = 2;

    logic [CW_W-1:0]   mem_q [DEPTH];
    logic [CW_W-1:0]   wr_cw;
    logic [CW_W-1:0]   fix_cw;
    logic [CW_W-1:0]   inj_mask;
    logic [CW_W-1:0]   dec_in  [NPORT];
    logic [DATA_W-1:0] dec_dat [NPORT];
    logic              dec_err [NPORT];
    logic [AW-1:0]     scrub_ptr;
    logic              scrub_wb;
    logic              host_wr;
    logic              host_rd;

    assign host_wr = req_valid && req_we;
    assign host_rd = req_valid && !req_we;

    // Encode host write data.
    sec_encoder #(.DATA_W(DATA_W)) u_enc_wr (
        .data_i (req_wdata),
        .cw_o   (wr_cw)
    );

    // Select the codewords seen by the host and scrub decoders.
    always_comb begin
        dec_in[PORT_HOST]  = mem_q[req_addr];
        dec_in[PORT_SCRUB] = mem_q[scrub_ptr];
    end

    // One decoder per reader.
    for (genvar g = 0; g < NPORT; g++) begin : g_dec
        sec_decoder #(.DATA_W(DATA_W)) u_dec (
            .cw_i   (dec_in[g]),
            .data_o (dec_dat[g]),
            .err_o  (dec_err[g])
        );
    end

    // Re-encode repaired scrub data for write-back.
    sec_encoder #(.DATA_W(DATA_W)) u_enc_fix (
        .data_i (dec_dat[PORT_SCRUB]),
        .cw_o   (fix_cw)
    );

    // Scrub pointer and repair counter.
    sec_scrub_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .scrub_en_i  (scrub_en),
        .host_busy_i (req_valid),
        .word_err_i  (dec_err[PORT_SCRUB]),
        .err_clr_i   (err_clr),
        .ptr_o       (scrub_ptr),
        .wb_en_o     (scrub_wb),
        .count_o     (err_count)
    );

    // Test mask: one bit for an in-range index, nothing otherwise.
    always_comb begin
        inj_mask = '0;
        if (inj_valid && (int'(inj_bit) < CW_W)) begin
            inj_mask[inj_bit] = 1'b1;
        end
    end

    // Per-word storage: host write or scrub write-back, then test inversion.
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [CW_W-1:0] nxt;
        logic            hit_inj;

        // Work out the next content of this word.
        always_comb begin
            hit_inj = (inj_addr == AW'(w));
            nxt     = mem_q[w];
            if (host_wr && (req_addr == AW'(w))) begin
                nxt = wr_cw;
            end else if (scrub_wb && (scrub_ptr == AW'(w))) begin
                nxt = fix_cw;
            end
            if (hit_inj) begin
                nxt = nxt ^ inj_mask;
            end
        end

        // Store the word; reset leaves the all-zero valid codeword.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[w] <= '0;
            end else begin
                mem_q[w] <= nxt;
            end
        end
    end

    // Register host read results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid     <= 1'b0;
            rd_corrected <= 1'b0;
            rd_data      <= '0;
        end else begin
            rd_valid     <= host_rd;
            rd_corrected <= host_rd && dec_err[PORT_HOST];
            if (host_rd) begin
                rd_data <= dec_dat[PORT_HOST];
            end
        end
    end

    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> rd_valid);

    p_valid_needs_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(host_rd));

    p_flag_in_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_corrected |-> rd_valid);

    p_no_wb_under_host_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_wb |-> !req_valid);

    p_host_word_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !scrub_wb && !(inj_valid && inj_addr == req_addr)) |=>
            (mem_q[$past(req_addr)] == $past(mem_q[req_addr])));

endmodule

// File: tb/sec_scrub_mem_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural model of data plus a per-word flip mask, compared every clock.
module sec_scrub_mem_tb_top;

    localparam int DEPTH = 16;
    localparam int CWB   = 136;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_we;
    logic [3:0]   req_addr;
    logic [127:0] req_wdata;
    logic         rd_valid, rd_corrected;
    logic [127:0] rd_data;
    logic         scrub_en, err_clr;
    logic [15:0]  err_count;
    logic         inj_valid;
    logic [3:0]   inj_addr;
    logic [7:0]   inj_bit;

    always #2.5 clk = ~clk;

    sec_scrub_mem dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_corrected(rd_corrected),
        .scrub_en(scrub_en), .err_clr(err_clr), .err_count(err_count),
        .inj_valid(inj_valid), .inj_addr(inj_addr), .inj_bit(inj_bit)
    );

    // Reference state
    logic [127:0] m_data [DEPTH];
    logic [CWB-1:0] m_mask [DEPTH];
    int           m_ptr;
    int           m_cnt;
    logic         e_rv, e_rc;
    logic [127:0] e_rd;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    task automatic chk(input bit ok, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // Model one clock edge using the inputs driven before it.
    task automatic model_step();
        bit hit;
        hit = 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_data[i] = '0;
                m_mask[i] = '0;
            end
            m_ptr = 0; m_cnt = 0; e_rv = 1'b0; e_rc = 1'b0;
        end else begin
            e_rv = req_valid && !req_we;
            e_rc = 1'b0;
            if (e_rv) begin
                e_rd = m_data[req_addr];
                e_rc = (m_mask[req_addr] != '0);
            end
            if (scrub_en && !req_valid) begin
                if (m_mask[m_ptr] != '0) begin
                    m_mask[m_ptr] = '0;
                    hit = 1'b1;
                end
                m_ptr = (m_ptr + 1) % DEPTH;
            end
            if (req_valid && req_we) begin
                m_data[req_addr] = req_wdata;
                m_mask[req_addr] = '0;
            end
            if (err_clr) m_cnt = 0;
            else if (hit && m_cnt != 16'hFFFF) m_cnt++;
            if (inj_valid && inj_bit < CWB) begin
                m_mask[inj_addr][inj_bit] = ~m_mask[inj_addr][inj_bit];
            end
        end
    endtask

    task automatic compare();
        chk(rd_valid === e_rv, "rd_valid", 128'(rd_valid), 128'(e_rv));
        chk(err_count === 16'(m_cnt), "err_count", 128'(err_count), 128'(m_cnt));
        if (e_rv) begin
            chk(rd_data === e_rd, "rd_data", rd_data, e_rd);
            chk(rd_corrected === e_rc, "rd_corrected", 128'(rd_corrected), 128'(e_rc));
        end else begin
            chk(rd_corrected === 1'b0, "rd_corrected idle", 128'(rd_corrected), 128'(0));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic go_idle();
        req_valid = 1'b0; req_we = 1'b0; inj_valid = 1'b0; err_clr = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [127:0] d);
        req_valid = 1'b1; req_we = 1'b1; req_addr = 4'(a); req_wdata = d;
        tick(); go_idle();
    endtask

    task automatic do_read(input int a);
        req_valid = 1'b1; req_we = 1'b0; req_addr = 4'(a);
        tick(); go_idle();
    endtask

    task automatic do_inject(input int a, input int b);
        inj_valid = 1'b1; inj_addr = 4'(a); inj_bit = 8'(b);
        tick(); go_idle();
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(150000 * 5);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int bits [10] = '{0, 1, 2, 3, 7, 64, 100, 127, 128, 135};
        rst_n = 1'b0; scrub_en = 1'b0; req_addr = '0; req_wdata = '0;
        inj_addr = '0; inj_bit = '0;
        go_idle();

        // R1: reset state, then every word reads as zero.
        cur_req = "R1";
        wait_n(3);
        rst_n = 1'b1;
        tick();
        for (int a = 0; a < DEPTH; a++) do_read(a);

        // R2: write and read back several patterns.
        cur_req = "R2";
        for (int a = 0; a < DEPTH; a++)
            do_write(a, {4{32'hA5C3_0000 + 32'(a * 32'h1111)}});
        do_write(4, '1);
        do_write(5, {64{2'b10}});
        do_write(6, 128'h1);
        for (int a = 0; a < DEPTH; a++) do_read(a);
        do_read(7); tick(); do_read(7);

        // R3/R4/R5: single flips at data and check positions, read twice.
        for (int i = 0; i < 10; i++) begin
            cur_req = "R4";
            do_inject(3, bits[i]);
            do_read(3);
            cur_req = "R5";
            do_read(3);
            cur_req = "R3";
            do_write(3, {32'hDEAD_BEEF, 32'(i), 64'h0123_4567_89AB_CDEF});
            do_read(3);
        end

        // R10: out-of-range indices change nothing; write plus same-edge flip.
        cur_req = "R10";
        do_inject(8, 136);
        do_inject(8, 255);
        do_read(8);
        req_valid = 1'b1; req_we = 1'b1; req_addr = 4'd9; req_wdata = 128'hF0F0;
        inj_valid = 1'b1; inj_addr = 4'd9; inj_bit = 8'd20;
        tick(); go_idle();
        do_read(9);

        // R11: scrub off keeps damage and counter.
        cur_req = "R11";
        do_inject(2, 50);
        wait_n(20);
        do_read(2);

        // R6: scrub repairs, counts, wraps 15 -> 0.
        cur_req = "R6";
        do_inject(15, 135);
        do_inject(0, 0);
        scrub_en = 1'b1;
        wait_n(40);
        for (int a = 0; a < DEPTH; a++) do_read(a);

        // R7: host traffic interleaved with scrub steps.
        cur_req = "R7";
        do_inject(11, 77);
        do_inject(12, 4);
        for (int i = 0; i < 24; i++) begin
            do_read(i % DEPTH);
            tick();
            do_write((i + 3) % DEPTH, 128'(i) << 60);
        end
        wait_n(20);

        // R9: clear on the same edge as a repair.
        cur_req = "R9";
        inj_valid = 1'b1; inj_addr = 4'((m_ptr + 1) % DEPTH); inj_bit = 8'd33;
        tick(); go_idle();
        err_clr = 1'b1;
        tick(); go_idle();
        wait_n(3);

        // R8: drive the counter to saturation.
        cur_req = "R8";
        err_clr = 1'b1; tick(); go_idle();
        for (int i = 0; i < 65540; i++) begin
            inj_valid = 1'b1;
            inj_addr = 4'((m_ptr + 1) % DEPTH);
            inj_bit = 8'(i % CWB);
            tick();
        end
        go_idle();
        wait_n(20);
        cur_req = "R9";
        err_clr = 1'b1; tick(); go_idle();
        wait_n(2);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule